// File: doc/BRIEF.md
# Memory protection region checker

This block sits beside a processor's load/store and fetch path and decides, for every memory access, whether the access may proceed or must raise a memory-management fault. Eight programmable address windows are held in the block. Each window has an inclusive base and limit address at 32-byte granularity, an enable, a read-only bit, a bit that opens the window to unprivileged code, an execute-never flag, a shareability code and an index into eight memory-attribute slots. Software loads a whole window in one write through a register port and can read any window back. A three-bit control word holds a global enable, a privileged-background enable and a bit that keeps checking active inside hard-fault, NMI and fault-masked handlers.

Each request carries an address, an access kind, a privilege flag and an exception context. The verdict is formed combinationally from the stored windows. It is registered once, so the block returns the allow/fault result, a region-hit flag, the matched region number and that region's attribute index exactly one cycle after a valid request. An address that lands in no enabled window falls to the background region. Only privileged code may use the background region, and only when that is enabled.

Top module: `mpu_region_check`

## Requirements
- R1: After reset every region is disabled, reads back base 0x00000000, limit 0x0000001F, all flag bits 0, shareability 00 and attribute index equal to its own region number. All three control bits are clear.
- R2: A region write stores the base with address bits [4:0] forced to 0 and the limit with bits [4:0] forced to 1. An address matches an enabled region when base <= address <= limit, with both ends included.
- R3: For a matched region, a read needs req_priv=1 or the unprivileged-enable bit =1. A write additionally needs the read-only bit =0. Access kind encoding: 00 read, 01 write, 10 fetch, 11 treated as read.
- R4: A fetch (kind 10) in a matched region is allowed only when execute-never is 0 and the requester has read access to the region. Otherwise it faults, and it still reports the hit, the region and the attribute index.
- R5: An enabled, checked access that matches no enabled region is allowed only when the privileged-background control is 1 and req_priv=1. Otherwise it faults. Either way rsp_hit=0.
- R6: When the handler-check control is 0, a request with a context other than normal is allowed with rsp_hit=0. Context encoding: 00 normal, 01 hard fault, 10 NMI, 11 fault-masked. When the control is 1, such a request is checked like a normal one.
- R7: Writing a region with cfg_en=0 turns it off, so it matches no address.
- R8: A pulse on attr_restore sets every region's attribute index back to its own region number. A hit reports the matched region's attribute index on rsp_attr.
- R9: Shareability codes 00 (none), 10 (outer) and 11 (inner) are stored as written. A write carrying code 01 leaves the region unchanged, and cfg_err is 1 in the cycle after that write and 0 otherwise.
- R10: While the global enable is 0, every request is allowed with rsp_hit=0, rsp_region=0 and rsp_attr=0.
- R11: A checked request whose address lies in two or more enabled regions faults, with rsp_hit=0.
- R12: rsp_valid is 1 exactly in the cycle after a cycle with req_valid=1. Result fields are 0 when rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one region's full configuration |
| cfg_idx | input | 3 | Region number to write |
| cfg_base | input | 32 | Base address (low five bits dropped) |
| cfg_limit | input | 32 | Limit address (low five bits forced high) |
| cfg_en | input | 1 | Region enable |
| cfg_ro | input | 1 | Read-only bit |
| cfg_unpriv | input | 1 | Allow unprivileged access |
| cfg_xn | input | 1 | Execute-never |
| cfg_share | input | 2 | Shareability code |
| cfg_attr | input | 3 | Attribute slot index |
| attr_restore | input | 1 | Restore identity attribute indices |
| ctl_we | input | 1 | Write the control word |
| ctl_enable | input | 1 | Global checking enable |
| ctl_privbg | input | 1 | Privileged background access enable |
| ctl_hfnmi | input | 1 | Keep checking inside fault/NMI handlers |
| cfg_err | output | 1 | Reserved shareability write was rejected |
| rd_idx | input | 3 | Region number to read back |
| rd_base | output | 32 | Stored base |
| rd_limit | output | 32 | Stored limit |
| rd_en | output | 1 | Stored enable |
| rd_ro | output | 1 | Stored read-only bit |
| rd_unpriv | output | 1 | Stored unprivileged-enable bit |
| rd_xn | output | 1 | Stored execute-never |
| rd_share | output | 2 | Stored shareability |
| rd_attr | output | 3 | Stored attribute index |
| req_valid | input | 1 | Access request valid |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | Access kind |
| req_priv | input | 1 | Requester is privileged |
| req_ctx | input | 2 | Exception context |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access must fault |
| rsp_hit | output | 1 | A single enabled region matched |
| rsp_region | output | 3 | Matched region number |
| rsp_attr | output | 3 | Matched region's attribute index |

## Verification
A corrupted window register shows up on the next request to an address near that window's edges. It also shows up at once on the readback port, so boundary addresses one byte inside and outside each window are driven, and every stored field is read back after each write. A stuck or wrongly decoded control bit flips the verdict for background, handler-context or globally-disabled requests, and that change appears one cycle after the request. Overlap and priority mistakes show as a wrong region number or a missing fault on the first access to a shared address.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;

    localparam int ADDR_W = 32;
    localparam int GRAN_W = 5;
    localparam int ATTR_W = 3;
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << GRAN_W) - 1);

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_ALT   = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CTX_THREAD  = 2'b00,
        CTX_HARDFLT = 2'b01,
        CTX_NMI     = 2'b10,
        CTX_FMASK   = 2'b11
    } ctx_e;

    typedef enum logic [1:0] {
        SH_NON   = 2'b00,
        SH_RSVD  = 2'b01,
        SH_OUTER = 2'b10,
        SH_INNER = 2'b11
    } share_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              en;
    } win_t;

    typedef struct packed {
        logic              ro;
        logic              unpriv;
        logic              xn;
        logic [ATTR_W-1:0] attr;
    } acc_t;

    typedef struct packed {
        win_t   win;
        acc_t   acc;
        share_e share;
    } rgn_cfg_t;

    function automatic rgn_cfg_t align_rgn(input rgn_cfg_t c);
        rgn_cfg_t r;
        r = c;
        r.win.base  = c.win.base & ~LOW_MASK;
        r.win.limit = c.win.limit | LOW_MASK;
        return r;
    endfunction

    function automatic logic perm_ok(input acc_kind_e k, input logic priv, input acc_t a);
        logic rd;
        rd = priv | a.unpriv;
        case (k)
            ACC_WRITE: return rd & ~a.ro;
            ACC_FETCH: return rd & ~a.xn;
            default:   return rd;
        endcase
    endfunction

    function automatic logic ctx_bypass(input ctx_e c, input logic hfnmi);
        return (c != CTX_THREAD) && !hfnmi;
    endfunction

endpackage

// File: rtl/mpu_rgn_bank.sv
module mpu_rgn_bank
    import mpu_chk_pkg::*;
#(
    parameter int N_REG = 8,
    localparam int IDX_W = $clog2(N_REG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  rgn_cfg_t               wr_cfg,
    input  logic                   attr_rst,
    input  logic [IDX_W-1:0]       rd_idx,
    output rgn_cfg_t               rd_cfg,
    output win_t [N_REG-1:0]       win_o,
    output acc_t [N_REG-1:0]       acc_o,
    output logic                   share_err
);

    rgn_cfg_t tbl [N_REG];
    rgn_cfg_t wr_aligned;
    logic     wr_ok;

    assign wr_aligned = align_rgn(wr_cfg);
    assign wr_ok      = wr_en && (wr_cfg.share != SH_RSVD);

    for (genvar g = 0; g < N_REG; g++) begin : g_rgn
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[g].win.base   <= '0;
                tbl[g].win.limit  <= LOW_MASK;
                tbl[g].win.en     <= 1'b0;
                tbl[g].acc.ro     <= 1'b0;
                tbl[g].acc.unpriv <= 1'b0;
                tbl[g].acc.xn     <= 1'b0;
                tbl[g].acc.attr   <= ATTR_W'(g);
                tbl[g].share      <= SH_NON;
            end else if (wr_ok && (wr_idx == IDX_W'(g))) begin
                tbl[g] <= wr_aligned;
            end else if (attr_rst) begin
                tbl[g].acc.attr <= ATTR_W'(g);
            end
        end
        assign win_o[g] = tbl[g].win;
        assign acc_o[g] = tbl[g].acc;
    end

    assign rd_cfg = tbl[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) share_err <= 1'b0;
        else     share_err <= wr_en && (wr_cfg.share == SH_RSVD);
    end

endmodule

// File: rtl/mpu_rgn_match.sv
module mpu_rgn_match
    import mpu_chk_pkg::*;
#(
    parameter int N_REG = 8,
    localparam int IDX_W = $clog2(N_REG),
    localparam int CNT_W = $clog2(N_REG + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  win_t [N_REG-1:0]  win_i,
    output logic [N_REG-1:0]  hit_vec,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              multi
);

    logic [CNT_W-1:0] cnt;

    for (genvar g = 0; g < N_REG; g++) begin : g_cmp
        assign hit_vec[g] = win_i[g].en
                         && (addr >= win_i[g].base)
                         && (addr <= win_i[g].limit);
    end

    always_comb begin
        cnt     = '0;
        sel_idx = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (hit_vec[i]) begin
                cnt     = cnt + 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
        multi = (cnt > CNT_W'(1));
    end

endmodule

// File: rtl/mpu_access_decide.sv
module mpu_access_decide
    import mpu_chk_pkg::*;
#(
    parameter int N_REG = 8,
    localparam int IDX_W = $clog2(N_REG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  acc_kind_e         kind,
    input  logic              priv,
    input  ctx_e              ctx,
    input  logic              en,
    input  logic              privbg,
    input  logic              hfnmi,
    input  logic              any_hit,
    input  logic              multi,
    input  logic [IDX_W-1:0]  sel_idx,
    input  acc_t              sel_acc,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_region,
    output logic [ATTR_W-1:0] rsp_attr
);

    logic              n_fault;
    logic              n_hit;
    logic [IDX_W-1:0]  n_region;
    logic [ATTR_W-1:0] n_attr;

    always_comb begin
        n_fault  = 1'b0;
        n_hit    = 1'b0;
        n_region = '0;
        n_attr   = '0;
        if (!en || ctx_bypass(ctx, hfnmi)) begin
            n_fault = 1'b0;
        end else if (multi) begin
            n_fault = 1'b1;
        end else if (any_hit) begin
            n_hit    = 1'b1;
            n_region = sel_idx;
            n_attr   = sel_acc.attr;
            n_fault  = !perm_ok(kind, priv, sel_acc);
        end else begin
            n_fault = !(privbg && priv);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_region <= '0;
            rsp_attr   <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_fault  <= req_valid & n_fault;
            rsp_hit    <= req_valid & n_hit;
            rsp_region <= req_valid ? n_region : '0;
            rsp_attr   <= req_valid ? n_attr : '0;
        end
    end

endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
    import mpu_chk_pkg::*;
#(
    parameter int N_REG = 8,
    localparam int IDX_W = $clog2(N_REG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic              cfg_en,
    input  logic              cfg_ro,
    input  logic              cfg_unpriv,
    input  logic              cfg_xn,
    input  logic [1:0]        cfg_share,
    input  logic [ATTR_W-1:0] cfg_attr,
    input  logic              attr_restore,
    input  logic              ctl_we,
    input  logic              ctl_enable,
    input  logic              ctl_privbg,
    input  logic              ctl_hfnmi,
    output logic              cfg_err,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_limit,
    output logic              rd_en,
    output logic              rd_ro,
    output logic              rd_unpriv,
    output logic              rd_xn,
    output logic [1:0]        rd_share,
    output logic [ATTR_W-1:0] rd_attr,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    input  logic [1:0]        req_ctx,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_region,
    output logic [ATTR_W-1:0] rsp_attr
);

    logic                en_q, privbg_q, hfnmi_q;
    rgn_cfg_t            wr_cfg, rd_cfg;
    win_t [N_REG-1:0]    win_arr;
    acc_t [N_REG-1:0]    acc_arr;
    logic [N_REG-1:0]    hit_vec;
    logic [IDX_W-1:0]    sel_idx;
    logic                multi;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            privbg_q <= 1'b0;
            hfnmi_q  <= 1'b0;
        end else if (ctl_we) begin
            en_q     <= ctl_enable;
            privbg_q <= ctl_privbg;
            hfnmi_q  <= ctl_hfnmi;
        end
    end

    always_comb begin
        wr_cfg.win.base   = cfg_base;
        wr_cfg.win.limit  = cfg_limit;
        wr_cfg.win.en     = cfg_en;
        wr_cfg.acc.ro     = cfg_ro;
        wr_cfg.acc.unpriv = cfg_unpriv;
        wr_cfg.acc.xn     = cfg_xn;
        wr_cfg.acc.attr   = cfg_attr;
        wr_cfg.share      = share_e'(cfg_share);
    end

    mpu_rgn_bank #(.N_REG(N_REG)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_cfg    (wr_cfg),
        .attr_rst  (attr_restore),
        .rd_idx    (rd_idx),
        .rd_cfg    (rd_cfg),
        .win_o     (win_arr),
        .acc_o     (acc_arr),
        .share_err (cfg_err)
    );

    assign rd_base   = rd_cfg.win.base;
    assign rd_limit  = rd_cfg.win.limit;
    assign rd_en     = rd_cfg.win.en;
    assign rd_ro     = rd_cfg.acc.ro;
    assign rd_unpriv = rd_cfg.acc.unpriv;
    assign rd_xn     = rd_cfg.acc.xn;
    assign rd_share  = rd_cfg.share;
    assign rd_attr   = rd_cfg.acc.attr;

    mpu_rgn_match #(.N_REG(N_REG)) u_match (
        .addr    (req_addr),
        .win_i   (win_arr),
        .hit_vec (hit_vec),
        .sel_idx (sel_idx),
        .multi   (multi)
    );

    mpu_access_decide #(.N_REG(N_REG)) u_decide (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .kind       (acc_kind_e'(req_kind)),
        .priv       (req_priv),
        .ctx        (ctx_e'(req_ctx)),
        .en         (en_q),
        .privbg     (privbg_q),
        .hfnmi      (hfnmi_q),
        .any_hit    (|hit_vec),
        .multi      (multi),
        .sel_idx    (sel_idx),
        .sel_acc    (acc_arr[sel_idx]),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_hit    (rsp_hit),
        .rsp_region (rsp_region),
        .rsp_attr   (rsp_attr)
    );

endmodule

// File: rtl/mpu_region_check_sva.sv
module mpu_region_check_sva #(
    parameter int N_REG = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_priv,
    input logic [1:0]       req_ctx,
    input logic             cfg_we,
    input logic [1:0]       cfg_share,
    input logic             cfg_err,
    input logic             en_q,
    input logic             privbg_q,
    input logic             hfnmi_q,
    input logic [N_REG-1:0] hit_vec,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic             rsp_hit
);

    logic checked;
    assign checked = req_valid && en_q && ((req_ctx == 2'b00) || hfnmi_q);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R12
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_fault && !rsp_hit); // R12
    AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid && !en_q |=> !rsp_fault && !rsp_hit); // R10
    AST_HANDLER_BYPASS: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_ctx != 2'b00) && !hfnmi_q |=> !rsp_fault && !rsp_hit); // R6
    AST_OVERLAP_FAULT: assert property (@(posedge clk) disable iff (rst)
        checked && ($countones(hit_vec) > 1) |=> rsp_fault && !rsp_hit); // R11
    AST_BG_GUARD: assert property (@(posedge clk) disable iff (rst)
        checked && (hit_vec == '0) && !(privbg_q && req_priv) |=> rsp_fault && !rsp_hit); // R5
    AST_SHARE_REJECT: assert property (@(posedge clk) disable iff (rst)
        cfg_we && (cfg_share == 2'b01) |=> cfg_err); // R9
    AST_SHARE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && (cfg_share == 2'b01)) |=> !cfg_err); // R9

endmodule

bind mpu_region_check mpu_region_check_sva #(.N_REG(N_REG)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_priv  (req_priv),
    .req_ctx   (req_ctx),
    .cfg_we    (cfg_we),
    .cfg_share (cfg_share),
    .cfg_err   (cfg_err),
    .en_q      (en_q),
    .privbg_q  (privbg_q),
    .hfnmi_q   (hfnmi_q),
    .hit_vec   (hit_vec),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_hit   (rsp_hit)
);

// File: tb/sim_mpu_region_check.sv
module sim_mpu_region_check;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 0;
    logic [2:0]  cfg_idx = 0;
    logic [31:0] cfg_base = 0, cfg_limit = 0;
    logic        cfg_en = 0, cfg_ro = 0, cfg_unpriv = 0, cfg_xn = 0;
    logic [1:0]  cfg_share = 0;
    logic [2:0]  cfg_attr = 0;
    logic        attr_restore = 0;
    logic        ctl_we = 0, ctl_enable = 0, ctl_privbg = 0, ctl_hfnmi = 0;
    logic        cfg_err;
    logic [2:0]  rd_idx = 0;
    logic [31:0] rd_base, rd_limit;
    logic        rd_en, rd_ro, rd_unpriv, rd_xn;
    logic [1:0]  rd_share;
    logic [2:0]  rd_attr;
    logic        req_valid = 0;
    logic [31:0] req_addr = 0;
    logic [1:0]  req_kind = 0;
    logic        req_priv = 0;
    logic [1:0]  req_ctx = 0;
    logic        rsp_valid, rsp_fault, rsp_hit;
    logic [2:0]  rsp_region, rsp_attr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_item_t;
    exp_item_t sb[$];

    always #4 clk = ~clk;

    mpu_region_check u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                chk("R12 unexpected response", 64'(rsp_valid), 64'(0));
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                chk(it.tag, 64'({rsp_fault, rsp_hit, rsp_region, rsp_attr}), 64'(it.exp));
            end
        end
    end

    task automatic wr_rgn(input logic [2:0] idx, input logic [31:0] b, input logic [31:0] l,
                          input logic en, input logic ro, input logic up, input logic xn,
                          input logic [1:0] sh, input logic [2:0] at);
        @(negedge clk);
        cfg_we = 1; cfg_idx = idx; cfg_base = b; cfg_limit = l; cfg_en = en;
        cfg_ro = ro; cfg_unpriv = up; cfg_xn = xn; cfg_share = sh; cfg_attr = at;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wr_ctl(input logic e, input logic p, input logic h);
        @(negedge clk);
        ctl_we = 1; ctl_enable = e; ctl_privbg = p; ctl_hfnmi = h;
        @(negedge clk);
        ctl_we = 0;
    endtask

    // kind: 0 rd 1 wr 2 fetch; ctx: 0 normal 1 hf 2 nmi 3 fmask
    task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic p, input logic [1:0] c,
                       input logic f, input logic h, input logic [2:0] r, input logic [2:0] at,
                       input string tag);
        exp_item_t it;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_kind = k; req_priv = p; req_ctx = c;
        it.exp = {f, h, r, at};
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic rd_chk(input logic [2:0] idx, input logic [31:0] b, input logic [31:0] l,
                          input logic en, input logic [1:0] sh, input logic [2:0] at, input string tag);
        @(negedge clk);
        rd_idx = idx;
        #1;
        chk({tag, " base"},  64'(rd_base), 64'(b));
        chk({tag, " limit"}, 64'(rd_limit), 64'(l));
        chk({tag, " en"},    64'(rd_en), 64'(en));
        chk({tag, " share"}, 64'(rd_share), 64'(sh));
        chk({tag, " attr"},  64'(rd_attr), 64'(at));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd_chk(3, 32'h0, 32'h1F, 0, 2'b00, 3'd3, "R1 reset rgn3");
        chk("R1 reset flags", 64'({rd_ro, rd_unpriv, rd_xn}), 64'(0));
        chk("R1 idle rsp_valid", 64'(rsp_valid), 64'(0));
        acc(32'h1000, 0, 0, 0, 0, 0, 0, 0, "R1 R10 disabled allows");

        // R5 background
        wr_ctl(1, 0, 0);
        acc(32'h1000, 0, 1, 0, 1, 0, 0, 0, "R5 bg priv no privbg");
        wr_ctl(1, 1, 0);
        acc(32'h1000, 0, 1, 0, 0, 0, 0, 0, "R5 bg priv privbg");
        acc(32'h1000, 0, 0, 0, 1, 0, 0, 0, "R5 bg unpriv");

        // R2 alignment and boundaries
        wr_rgn(0, 32'h2000_0013, 32'h2000_0FE0, 1, 0, 1, 1, 2'b00, 3'd5);
        rd_chk(0, 32'h2000_0000, 32'h2000_0FFF, 1, 2'b00, 3'd5, "R2 readback");
        acc(32'h2000_0000, 1, 0, 0, 0, 1, 0, 5, "R2 R3 low edge unpriv write");
        acc(32'h2000_0FFF, 0, 0, 0, 0, 1, 0, 5, "R2 high edge read");
        acc(32'h2000_1000, 0, 0, 0, 1, 0, 0, 0, "R2 past limit");
        acc(32'h2000_0100, 2, 1, 0, 1, 1, 0, 5, "R4 fetch xn");

        // R3/R4 permissions
        wr_rgn(1, 32'h3000_0000, 32'h3000_00FF, 1, 1, 0, 0, 2'b10, 3'd1);
        acc(32'h3000_0010, 1, 1, 0, 1, 1, 1, 1, "R3 write ro");
        acc(32'h3000_0010, 0, 1, 0, 0, 1, 1, 1, "R3 priv read");
        acc(32'h3000_0010, 3, 0, 0, 1, 1, 1, 1, "R3 unpriv read kind11");
        acc(32'h3000_0010, 2, 1, 0, 0, 1, 1, 1, "R4 priv fetch");
        acc(32'h3000_0010, 2, 0, 0, 1, 1, 1, 1, "R4 unpriv fetch");

        // R11 overlap
        wr_rgn(2, 32'h3000_0080, 32'h3000_01FF, 1, 0, 1, 0, 2'b11, 3'd2);
        acc(32'h3000_0090, 0, 1, 0, 1, 0, 0, 0, "R11 overlap");
        acc(32'h3000_0100, 0, 0, 0, 0, 1, 2, 2, "R11 single rgn2");

        // R9 shareability
        wr_rgn(3, 32'h5000_0000, 32'h5000_0FFF, 1, 0, 1, 0, 2'b01, 3'd6);
        chk("R9 cfg_err pulse", 64'(cfg_err), 64'(1));
        @(negedge clk);
        chk("R9 cfg_err clears", 64'(cfg_err), 64'(0));
        rd_chk(3, 32'h0, 32'h1F, 0, 2'b00, 3'd3, "R9 rejected");
        rd_chk(2, 32'h3000_0080, 32'h3000_01FF, 1, 2'b11, 3'd2, "R9 inner");
        rd_chk(1, 32'h3000_0000, 32'h3000_00FF, 1, 2'b10, 3'd1, "R9 outer");
        acc(32'h5000_0000, 0, 0, 0, 1, 0, 0, 0, "R9 rejected no match");

        // R7 disable
        wr_rgn(2, 32'h3000_0080, 32'h3000_01FF, 0, 0, 1, 0, 2'b00, 3'd2);
        acc(32'h3000_0090, 0, 1, 0, 0, 1, 1, 1, "R7 only rgn1");
        acc(32'h3000_0100, 0, 0, 0, 1, 0, 0, 0, "R7 off falls to bg");

        // R8 attribute restore
        @(negedge clk); attr_restore = 1;
        @(negedge clk); attr_restore = 0;
        rd_chk(0, 32'h2000_0000, 32'h2000_0FFF, 1, 2'b00, 3'd0, "R8 restore");
        acc(32'h2000_0040, 0, 0, 0, 0, 1, 0, 0, "R8 attr out");

        // R6 handler contexts
        acc(32'h4000_0000, 0, 0, 1, 0, 0, 0, 0, "R6 hardfault bypass");
        acc(32'h3000_0010, 1, 0, 2, 0, 0, 0, 0, "R6 nmi bypass");
        acc(32'h4000_0000, 1, 0, 3, 0, 0, 0, 0, "R6 fmask bypass");
        wr_ctl(1, 1, 1);
        acc(32'h4000_0000, 0, 0, 1, 1, 0, 0, 0, "R6 hardfault checked");
        acc(32'h3000_0010, 1, 1, 2, 1, 1, 1, 1, "R6 nmi checked");

        // R10 global off
        wr_ctl(0, 0, 0);
        acc(32'h3000_0010, 1, 0, 0, 0, 0, 0, 0, "R10 off write");

        // R12 response lasts one cycle
        @(negedge clk);
        chk("R12 single cycle", 64'(rsp_valid), 64'(0));
        repeat (2) @(negedge clk);
        chk("R12 scoreboard drained", 64'(sb.size()), 64'(0));
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule